// File: doc/BRIEF.md
# Integer ALU with Word-Result Extension

This block is the integer arithmetic and logic unit of a 64-bit execution stage. It is purely combinational. Given two register operands, a short immediate and an opcode, it returns a 64-bit result in the same cycle. Besides full-width arithmetic it offers word (32-bit) variants. These compute on the low halves and define the upper half of the result explicitly, so compiled code that keeps 32-bit integers canonical in 64-bit registers needs no separate extension instructions.

Add and subtract each come in three result modes: full width, word sign-extended and word zero-extended. A register-plus-immediate add takes a 9-bit signed immediate in the same three modes. There is no subtract-immediate form; software negates the immediate instead. AND, OR and XOR exist only at full width. The three shifts come in full-width and word forms. Word right shifts first extend the source word according to the shift type, and all word shifts sign-extend their result from bit 31. A word add with a zero second operand therefore works as a plain 32-to-64 sign extension.

Top module: `wordext_alu`

## Requirements
- R1: Opcode 0 gives a+b and opcode 3 gives a-b, both over all 64 bits with wraparound. With all inputs at zero the result is zero.
- R2: Opcodes 1 (add) and 4 (sub) compute on the low 32 bits and return that 32-bit result sign-extended from bit 31.
- R3: Opcodes 2 (add) and 5 (sub) compute on the low 32 bits and return that 32-bit result with bits 63:32 cleared.
- R4: Opcodes 6, 7 and 8 add a to the immediate sign-extended from its 9 bits, with results in the full, word sign-extended and word zero-extended modes respectively. Adding a negated immediate performs subtraction.
- R5: Opcodes 9, 10 and 11 give the full 64-bit bitwise AND, OR and XOR of a and b.
- R6: Opcodes 12 (left), 13 (logical right) and 14 (arithmetic right) shift a by b[5:0]. Bits 63:6 of b are ignored.
- R7: Opcode 15 shifts the low word of a left by b[4:0] and sign-extends bit 31 of the shifted value. Bits 63:5 of b are ignored.
- R8: Opcode 16 zero-extends a[31:0] and opcode 17 sign-extends a[31:0] to 64 bits. Either then shifts right by b[4:0] and sign-extends the result from bit 31. With a zero shift amount, opcode 16 still returns a sign-extended word.
- R9: Bits 63:32 of both operands have no effect on any word add or subtract. Opcode 1 with b equal to zero returns a[31:0] sign-extended.
- R10: Opcodes 18 to 31 return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation and result-mode select |
| src_a_i | input | 64 | First operand, also the shift source |
| src_b_i | input | 64 | Second operand, also the shift amount |
| imm_i | input | 9 | Signed immediate for the register-plus-immediate forms |
| result_o | output | 64 | Result |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath, a 32-bit word and a 9-bit immediate. At these widths the sign boundary at bit 31 can be driven directly from table vectors. Carries out of the low word, shift amounts whose ignored upper bits are set, the all-ones immediate and the zero-amount logical word shift can all be placed so that each result mode gives a different answer.

// File: rtl/wordext_alu_pkg.sv
package wordext_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_ADDWS  = 5'd1,
    OP_ADDWZ  = 5'd2,
    OP_SUB    = 5'd3,
    OP_SUBWS  = 5'd4,
    OP_SUBWZ  = 5'd5,
    OP_ADDI   = 5'd6,
    OP_ADDIWS = 5'd7,
    OP_ADDIWZ = 5'd8,
    OP_AND    = 5'd9,
    OP_OR     = 5'd10,
    OP_XOR    = 5'd11,
    OP_SLL    = 5'd12,
    OP_SRL    = 5'd13,
    OP_SRA    = 5'd14,
    OP_SLLW   = 5'd15,
    OP_SRLW   = 5'd16,
    OP_SRAW   = 5'd17
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_ADD   = 2'd1,
    UNIT_LOGIC = 2'd2,
    UNIT_SHIFT = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    EXT_FULL = 2'd0,
    EXT_SEXT = 2'd1,
    EXT_ZEXT = 2'd2
  } ext_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shk_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lgk_e;

  typedef struct packed {
    unit_e unit;
    logic  sub;
    logic  use_imm;
    ext_e  ext;
    shk_e  shk;
    lgk_e  lgk;
    logic  word;
  } ctrl_t;

endpackage

// File: rtl/wordext_alu_addsub.sv
module wordext_alu_addsub #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 9
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  output logic [XLEN-1:0]  sum_o
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] rhs;
  logic [XLEN-1:0] rhs_inv;

  always_comb begin
    imm_ext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    rhs     = use_imm_i ? imm_ext : b_i;
    rhs_inv = sub_i ? ~rhs : rhs;
    sum_o   = a_i + rhs_inv + {{(XLEN-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/wordext_alu_shift.sv
module wordext_alu_shift #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  wordext_alu_pkg::shk_e shk_i,
  input  logic            word_i,
  output logic [XLEN-1:0] sh_o
);
  import wordext_alu_pkg::*;
  localparam int SH_W  = $clog2(XLEN);
  localparam int WSH_W = $clog2(WLEN);
  localparam int HI_W  = XLEN - WLEN;

  logic [SH_W-1:0] amt;
  logic [XLEN-1:0] src;
  logic            fill;

  always_comb begin
    if (word_i) begin
      amt  = {{(SH_W-WSH_W){1'b0}}, b_i[WSH_W-1:0]};
      fill = (shk_i == SH_RARI) ? a_i[WLEN-1] : 1'b0;
      src  = {{HI_W{fill}}, a_i[WLEN-1:0]};
    end else begin
      amt  = b_i[SH_W-1:0];
      fill = 1'b0;
      src  = a_i;
    end
    unique case (shk_i)
      SH_LEFT: sh_o = src << amt;
      SH_RLOG: sh_o = src >> amt;
      SH_RARI: sh_o = XLEN'($signed(src) >>> amt);
      default: sh_o = '0;
    endcase
  end
endmodule

// File: rtl/wordext_alu_extend.sv
module wordext_alu_extend #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] raw_i,
  input  wordext_alu_pkg::ext_e ext_i,
  output logic [XLEN-1:0] res_o
);
  import wordext_alu_pkg::*;
  localparam int HI_W = XLEN - WLEN;

  logic [HI_W-1:0] hi_sel;

  for (genvar g = 0; g < HI_W; g++) begin : g_hi
    always_comb begin
      unique case (ext_i)
        EXT_SEXT: hi_sel[g] = raw_i[WLEN-1];
        EXT_ZEXT: hi_sel[g] = 1'b0;
        default:  hi_sel[g] = raw_i[WLEN+g];
      endcase
    end
  end

  assign res_o = {hi_sel, raw_i[WLEN-1:0]};
endmodule

// File: rtl/wordext_alu.sv
module wordext_alu #(
  parameter int XLEN  = 64,
  parameter int WLEN  = 32,
  parameter int IMM_W = 9
) (
  input  logic [4:0]       op_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o
);
  import wordext_alu_pkg::*;

  ctrl_t           ctl;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] shv;
  logic [XLEN-1:0] lgv;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] ext_res;

  always_comb begin
    ctl = '{unit: UNIT_NONE, sub: 1'b0, use_imm: 1'b0, ext: EXT_FULL,
            shk: SH_LEFT, lgk: LG_AND, word: 1'b0};
    unique case (op_i)
      OP_ADD:    ctl.unit = UNIT_ADD;
      OP_ADDWS:  begin ctl.unit = UNIT_ADD; ctl.ext = EXT_SEXT; end
      OP_ADDWZ:  begin ctl.unit = UNIT_ADD; ctl.ext = EXT_ZEXT; end
      OP_SUB:    begin ctl.unit = UNIT_ADD; ctl.sub = 1'b1; end
      OP_SUBWS:  begin ctl.unit = UNIT_ADD; ctl.sub = 1'b1; ctl.ext = EXT_SEXT; end
      OP_SUBWZ:  begin ctl.unit = UNIT_ADD; ctl.sub = 1'b1; ctl.ext = EXT_ZEXT; end
      OP_ADDI:   begin ctl.unit = UNIT_ADD; ctl.use_imm = 1'b1; end
      OP_ADDIWS: begin ctl.unit = UNIT_ADD; ctl.use_imm = 1'b1; ctl.ext = EXT_SEXT; end
      OP_ADDIWZ: begin ctl.unit = UNIT_ADD; ctl.use_imm = 1'b1; ctl.ext = EXT_ZEXT; end
      OP_AND:    ctl.unit = UNIT_LOGIC;
      OP_OR:     begin ctl.unit = UNIT_LOGIC; ctl.lgk = LG_OR; end
      OP_XOR:    begin ctl.unit = UNIT_LOGIC; ctl.lgk = LG_XOR; end
      OP_SLL:    ctl.unit = UNIT_SHIFT;
      OP_SRL:    begin ctl.unit = UNIT_SHIFT; ctl.shk = SH_RLOG; end
      OP_SRA:    begin ctl.unit = UNIT_SHIFT; ctl.shk = SH_RARI; end
      OP_SLLW:   begin ctl.unit = UNIT_SHIFT; ctl.word = 1'b1; ctl.ext = EXT_SEXT; end
      OP_SRLW:   begin ctl.unit = UNIT_SHIFT; ctl.word = 1'b1; ctl.ext = EXT_SEXT;
                       ctl.shk = SH_RLOG; end
      OP_SRAW:   begin ctl.unit = UNIT_SHIFT; ctl.word = 1'b1; ctl.ext = EXT_SEXT;
                       ctl.shk = SH_RARI; end
      default:   ctl.unit = UNIT_NONE;
    endcase
  end

  wordext_alu_addsub #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addsub (
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .imm_i     (imm_i),
    .use_imm_i (ctl.use_imm),
    .sub_i     (ctl.sub),
    .sum_o     (sum)
  );

  wordext_alu_shift #(.XLEN(XLEN), .WLEN(WLEN)) u_shift (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .shk_i  (ctl.shk),
    .word_i (ctl.word),
    .sh_o   (shv)
  );

  always_comb begin
    unique case (ctl.lgk)
      LG_OR:   lgv = src_a_i | src_b_i;
      LG_XOR:  lgv = src_a_i ^ src_b_i;
      default: lgv = src_a_i & src_b_i;
    endcase
    unique case (ctl.unit)
      UNIT_ADD:   raw = sum;
      UNIT_LOGIC: raw = lgv;
      UNIT_SHIFT: raw = shv;
      default:    raw = '0;
    endcase
  end

  wordext_alu_extend #(.XLEN(XLEN), .WLEN(WLEN)) u_extend (
    .raw_i (raw),
    .ext_i (ctl.ext),
    .res_o (ext_res)
  );

  assign result_o = ext_res;
endmodule

// File: rtl/wordext_alu_chk.sv
module wordext_alu_chk #(
  parameter int XLEN  = 64,
  parameter int WLEN  = 32,
  parameter int IMM_W = 9
) (
  input logic [4:0]       op_i,
  input logic [XLEN-1:0]  src_a_i,
  input logic [XLEN-1:0]  src_b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  result_o
);
  localparam int HI_W = XLEN - WLEN;

  logic known;
  logic sext_op;
  logic zext_op;

  always_comb begin
    known   = !$isunknown({op_i, src_a_i, src_b_i, imm_i, result_o});
    sext_op = (op_i == 5'd1) || (op_i == 5'd4) || (op_i == 5'd7) ||
              (op_i == 5'd15) || (op_i == 5'd16) || (op_i == 5'd17);
    zext_op = (op_i == 5'd2) || (op_i == 5'd5) || (op_i == 5'd8);
    if (known) begin
      // R1: full-width add and subtract invert each other
      assert_add_inverse_R1: assert (op_i != 5'd0 || result_o - src_b_i == src_a_i);
      assert_sub_inverse_R1: assert (op_i != 5'd3 || result_o + src_b_i == src_a_i);
      // R2, R7, R8: sign-extended word forms have a uniform upper half
      assert_word_sext_R2: assert (!sext_op ||
        result_o[XLEN-1:WLEN] == {HI_W{result_o[WLEN-1]}});
      // R3: zero-extended word forms clear the upper half
      assert_word_zext_R3: assert (!zext_op || result_o[XLEN-1:WLEN] == '0);
      // R5: AND result lies within both operands, OR result covers both
      assert_and_subset_R5: assert (op_i != 5'd9 ||
        ((result_o & ~src_a_i) == '0 && (result_o & ~src_b_i) == '0));
      assert_or_cover_R5: assert (op_i != 5'd10 ||
        ((src_a_i & ~result_o) == '0 && (src_b_i & ~result_o) == '0));
      // R10: unassigned opcodes return zero
      assert_unused_zero_R10: assert (op_i < 5'd18 || result_o == '0);
    end
  end
endmodule

bind wordext_alu wordext_alu_chk #(.XLEN(XLEN), .WLEN(WLEN), .IMM_W(IMM_W)) u_chk (
  .op_i     (op_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .imm_i    (imm_i),
  .result_o (result_o)
);

// File: tb/sim_wordext_alu.sv
module sim_wordext_alu;
  localparam int VW = 4 + 5 + 64 + 64 + 9 + 64;
  localparam int NV = 26;

  // {req, op, a, b, imm, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1,  5'd0,  64'h0000_0000_7FFF_FFFF, 64'h1, 9'h0, 64'h0000_0000_8000_0000},
    {4'd2,  5'd1,  64'h0000_0000_7FFF_FFFF, 64'h1, 9'h0, 64'hFFFF_FFFF_8000_0000},
    {4'd3,  5'd2,  64'h0000_0000_7FFF_FFFF, 64'h1, 9'h0, 64'h0000_0000_8000_0000},
    {4'd1,  5'd3,  64'h0, 64'h1, 9'h0, 64'hFFFF_FFFF_FFFF_FFFF},
    {4'd3,  5'd5,  64'h0, 64'h1, 9'h0, 64'h0000_0000_FFFF_FFFF},
    {4'd2,  5'd4,  64'h5, 64'h3, 9'h0, 64'h2},
    {4'd9,  5'd1,  64'h1234_5678_8000_0000, 64'h0, 9'h0, 64'hFFFF_FFFF_8000_0000},
    {4'd4,  5'd6,  64'd10, 64'h0, 9'h1FF, 64'd9},
    {4'd4,  5'd6,  64'd10, 64'h0, 9'h0FF, 64'h109},
    {4'd4,  5'd7,  64'h0000_0000_7FFF_FFFF, 64'h0, 9'h001, 64'hFFFF_FFFF_8000_0000},
    {4'd4,  5'd8,  64'h0, 64'h0, 9'h1FE, 64'h0000_0000_FFFF_FFFE},
    {4'd5,  5'd9,  64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 9'h0, 64'hF000_F000_F000_F000},
    {4'd5,  5'd10, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 9'h0, 64'hFFF0_FFF0_FFF0_FFF0},
    {4'd5,  5'd11, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 9'h0, 64'h0FF0_0FF0_0FF0_0FF0},
    {4'd6,  5'd12, 64'h1, 64'd63, 9'h0, 64'h8000_0000_0000_0000},
    {4'd6,  5'd12, 64'h1, 64'h44, 9'h0, 64'h10},
    {4'd6,  5'd13, 64'h8000_0000_0000_0000, 64'd4, 9'h0, 64'h0800_0000_0000_0000},
    {4'd6,  5'd14, 64'h8000_0000_0000_0000, 64'd4, 9'h0, 64'hF800_0000_0000_0000},
    {4'd7,  5'd15, 64'h1, 64'd31, 9'h0, 64'hFFFF_FFFF_8000_0000},
    {4'd7,  5'd15, 64'h1, 64'd32, 9'h0, 64'h1},
    {4'd8,  5'd16, 64'hFFFF_FFFF_8000_0000, 64'd0, 9'h0, 64'hFFFF_FFFF_8000_0000},
    {4'd8,  5'd16, 64'hFFFF_FFFF_8000_0000, 64'd1, 9'h0, 64'h0000_0000_4000_0000},
    {4'd8,  5'd17, 64'h0000_0000_8000_0000, 64'd4, 9'h0, 64'hFFFF_FFFF_F800_0000},
    {4'd8,  5'd17, 64'hFFFF_FFFF_7000_0000, 64'd36, 9'h0, 64'h0000_0000_0700_0000},
    {4'd10, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 9'h1FF, 64'h0},
    {4'd9,  5'd2,  64'hFFFF_FFFF_0000_0001, 64'hAAAA_0000_0000_0001, 9'h0, 64'h2}
  };

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [63:0] a;
  logic [63:0] b;
  logic [8:0]  imm;
  logic [63:0] res;
  int          checks;
  int          errors;
  bit          done;

  wordext_alu u0 (
    .op_i     (op),
    .src_a_i  (a),
    .src_b_i  (b),
    .imm_i    (imm),
    .result_o (res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply(input logic [3:0] req, input logic [4:0] o, input logic [63:0] va,
                       input logic [63:0] vb, input logic [8:0] vi, input logic [63:0] exp);
    @(negedge clk);
    op = o; a = va; b = vb; imm = vi;
    #2;
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL R%0d op=%0d got %h expected %h", req, o, res, exp);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    op = '0; a = '0; b = '0; imm = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: all-zero inputs give a zero result
    apply(4'd1, 5'd0, 64'h0, 64'h0, 9'h0, 64'h0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][209:206], VEC[i][205:201], VEC[i][200:137],
            VEC[i][136:73], VEC[i][72:64], VEC[i][63:0]);
    end
    // R4: subtract performed through a negated immediate (-100)
    apply(4'd4, 5'd6, 64'd100, 64'h0, 9'h19C, 64'h0);
    // R8: arithmetic word shift by zero keeps the sign-extended word
    apply(4'd8, 5'd17, 64'h0000_0000_8000_0000, 64'd0, 9'h0, 64'hFFFF_FFFF_8000_0000);
    // R9: upper operand bits ignored by word subtract
    apply(4'd9, 5'd4, 64'h5555_0000_0000_0005, 64'h0F0F_0000_0000_0007, 9'h0, 64'hFFFF_FFFF_FFFF_FFFE);
    // R10: first unassigned opcode
    apply(4'd10, 5'd18, 64'h1, 64'h1, 9'h1, 64'h0);
    // R6: right shift amount with ignored upper bits set
    apply(4'd6, 5'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 9'h0, 64'h1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule